// File: doc/BRIEF.md
# Firmware Image Boot Sequencer

This block boots an embedded processor from a firmware image that already sits in a byte-wide source memory. After a start strobe it reads the image through a read port with one cycle of latency. It checks a CRC-16 over the whole image before it trusts any field. It then follows a relocatable header to two sections, one for code and one for data, and bounds-checks every derived offset against the image length. Finally it streams both sections, one 32-bit word per command, into a target mailbox write port.

During the load the target processor is held in stall with the stall override asserted. After both sections arrive, and the mailbox CRC agrees with the block's own CRC for each section, the block clears the soft-reset and low-power conditions. It then pulses the processor reset for a hold time set by the clock frequency and leaves only the override asserted. Any failure latches a distinct error code and halts the sequence before reset release.

Top module: `fwboot_seq`

## Requirements
- R1: On start, a CRC-16 (polynomial 0x1021, initial value 0, MSB first, no reflection, no final inversion) is computed over image bytes 0 to len-3. The result is compared with byte len-2 as the high half and byte len-1 as the low half. A mismatch, or a length below 2, ends the run with error code 1, and no mailbox write is made.
- R2: The base offset is a 16-bit value, low byte at image byte 8 and high byte at byte 9, shifted left by 12. The header starts at base+0x300 and holds 4 pad bytes, then four 3-byte little-endian fields: code offset, code size, data offset, data size. A length below 10, or base+0x310 beyond the length, gives error code 2.
- R3: A section size that is not a multiple of 4 gives error code 3. The code section is checked before the data section.
- R4: For each section, base+offset+size larger than the image length gives error code 4.
- R5: The version region starts at base+data offset+0x200 and spans 64 bytes. It must fit in the image and its first byte must be nonzero; otherwise error code 5.
- R6: With stall and override asserted, the data section is written first to consecutive word addresses from 0x3FFE0000. The code section follows from 0x40000000. Each mailbox word packs four consecutive image bytes, little-endian, and the mailbox CRC clear strobe pulses before each section.
- R7: After each section, a CRC-16 over the section bytes is compared with the mailbox CRC input. For each word the bytes are taken most significant first. A mismatch gives error code 6 with stall and override left asserted and reset never raised.
- R8: On success the block gives a one-cycle power-clear pulse. It then holds stall, override and reset together for CLK_HZ/1e6 x HOLD_US cycles, ends with only the override asserted, and raises done with error code 0.
- R9: An error raises err with its code and leaves done low and the processor reset low. A start while a run is in progress is ignored, and a new start clears the previous status.
- R10: After reset, done, err, the error code, rdEn, mbxWrEn, stall, override, reset and power-clear are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a boot run (accepted only when idle) |
| imgLen | input | LEN_W | Image length in bytes, held stable during a run |
| rdEn | output | 1 | Source memory read request |
| rdAddr | output | ADDR_W | Source memory byte address |
| rdData | input | 8 | Source byte, valid the cycle after rdEn |
| mbxWrEn | output | 1 | Mailbox word write command |
| mbxAddr | output | 32 | Mailbox target word address |
| mbxData | output | 32 | Mailbox write data |
| mbxCrcClr | output | 1 | Clears the mailbox CRC before a section |
| mbxCrc | input | 16 | CRC accumulated by the mailbox |
| cpuStall | output | 1 | Processor stall |
| cpuStallOvd | output | 1 | Stall override |
| cpuRst | output | 1 | Processor reset |
| pwrClr | output | 1 | Pulse clearing soft-reset and low-power |
| done | output | 1 | Boot finished successfully |
| err | output | 1 | Boot aborted |
| errCode | output | 3 | Failure cause, 0 when none |

## Verification
On every cycle the assertions check the invariants of the control outputs. Reset is only ever raised together with stall and override. Mailbox writes happen only under stall with word-aligned addresses. Reads stay inside the image. done and err are never both set, and an error always carries a nonzero code with reset low. The checker also counts how long reset stays high. Only the bench scenarios can show the arithmetic: the image CRC, header relocation, each bounds and alignment check with its error code, the exact packed word stream and its order, and the mailbox CRC comparison. They also show that a start during a run is ignored.

// File: rtl/fwboot_pkg.sv
package fwboot_pkg;

  localparam int          PRIM_FIELD_AT = 8;
  localparam int          HDR_AT        = 'h300;
  localparam int          HDR_PAD       = 4;
  localparam int          HDR_LEN       = 16;
  localparam int          VER_AT        = 'h200;
  localparam int          VER_LEN       = 64;
  localparam logic [31:0] DATA_BASE     = 32'h3FFE_0000;
  localparam logic [31:0] CODE_BASE     = 32'h4000_0000;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0, ERR_IMG_CRC = 3'd1, ERR_HDR = 3'd2, ERR_ALIGN = 3'd3,
    ERR_BOUND = 3'd4, ERR_VER = 3'd5, ERR_LOAD_CRC = 3'd6
  } err_e;

  typedef enum logic [2:0] {
    B_BODY, B_TRAIL, B_PRIM, B_FIELD, B_VER, B_WORD
  } burst_e;

  typedef struct packed {
    logic   burstGo;
    burst_e burstSel;
    logic   crcClr;
    logic   latchPrim;
    logic   latchField;
    logic   secInit;
    logic   secSel;
    logic   wordWr;
  } dp_ctrl_t;

  typedef struct packed {
    logic busy;
    logic lenOk;
    logic crcMatch;
    logic primFit;
    logic hdrFit;
    logic lastField;
    logic codeAlign;
    logic codeFit;
    logic dataAlign;
    logic dataFit;
    logic verFit;
    logic verNz;
    logic secDone;
    logic loadOk;
  } dp_stat_t;

  function automatic logic [15:0] crc16Step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

endpackage

// File: rtl/fwboot_dp.sv
module fwboot_dp
  import fwboot_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctl,
  input  logic [LEN_W-1:0]  imgLen,
  input  logic [7:0]        rdData,
  input  logic [15:0]       mbxCrc,
  output dp_stat_t          stat,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              mbxWrEn,
  output logic [31:0]       mbxAddr,
  output logic [31:0]       mbxData,
  output logic              mbxCrcClr
);
  localparam int EXT_W = LEN_W + 2;

  function automatic logic fits(input logic [LEN_W-1:0] a, b, c, lim);
    logic [EXT_W-1:0] s;
    s = EXT_W'(a) + EXT_W'(b) + EXT_W'(c);
    return s <= EXT_W'(lim);
  endfunction

  logic [LEN_W-1:0] ptr, cnt, prim, secPos, bStart, bLen, secBase, secSize;
  logic             desc, capEn, crcOn, bDesc, secIsCode;
  logic [31:0]      shiftR;
  logic [15:0]      crc;
  logic [23:0]      codeOff, codeSz, dataOff, dataSz;
  logic [1:0]       fieldIdx;

  assign secBase = prim + LEN_W'(secIsCode ? codeOff : dataOff);
  assign secSize = LEN_W'(secIsCode ? codeSz : dataSz);

  always_comb begin
    bDesc = 1'b0;
    case (ctl.burstSel)
      B_BODY:  begin bStart = '0;                  bLen = imgLen - LEN_W'(2); end
      B_TRAIL: begin bStart = imgLen - LEN_W'(2);  bLen = LEN_W'(2); end
      B_PRIM:  begin bStart = LEN_W'(PRIM_FIELD_AT + 1); bLen = LEN_W'(2); bDesc = 1'b1; end
      B_FIELD: begin
        bStart = prim + LEN_W'(HDR_AT + HDR_PAD + 2) + LEN_W'({fieldIdx, 1'b0}) + LEN_W'(fieldIdx);
        bLen   = LEN_W'(3);
        bDesc  = 1'b1;
      end
      B_VER:   begin bStart = prim + LEN_W'(dataOff) + LEN_W'(VER_AT); bLen = LEN_W'(1); end
      default: begin bStart = secBase + secPos + LEN_W'(3); bLen = LEN_W'(4); bDesc = 1'b1; end
    endcase
  end

  assign rdEn   = (cnt != '0);
  assign rdAddr = ptr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0; cnt <= '0; desc <= 1'b0; crcOn <= 1'b0; capEn <= 1'b0;
      shiftR <= '0; crc <= '0; prim <= '0; fieldIdx <= '0;
      codeOff <= '0; codeSz <= '0; dataOff <= '0; dataSz <= '0;
      secPos <= '0; secIsCode <= 1'b0;
      mbxWrEn <= 1'b0; mbxAddr <= '0; mbxData <= '0; mbxCrcClr <= 1'b0;
    end else begin
      capEn     <= rdEn;
      mbxWrEn   <= 1'b0;
      mbxCrcClr <= ctl.secInit;
      if (ctl.burstGo) begin
        ptr   <= bStart;
        cnt   <= bLen;
        desc  <= bDesc;
        crcOn <= (ctl.burstSel == B_BODY) || (ctl.burstSel == B_WORD);
      end else if (rdEn) begin
        ptr <= desc ? ptr - LEN_W'(1) : ptr + LEN_W'(1);
        cnt <= cnt - LEN_W'(1);
      end
      if (ctl.crcClr) crc <= '0;
      else if (capEn && crcOn) crc <= crc16Step(crc, rdData);
      if (capEn) shiftR <= {shiftR[23:0], rdData};
      if (ctl.latchPrim) begin
        prim     <= LEN_W'({shiftR[15:0], 12'h000});
        fieldIdx <= '0;
      end
      if (ctl.latchField) begin
        case (fieldIdx)
          2'd0:    codeOff <= shiftR[23:0];
          2'd1:    codeSz  <= shiftR[23:0];
          2'd2:    dataOff <= shiftR[23:0];
          default: dataSz  <= shiftR[23:0];
        endcase
        fieldIdx <= fieldIdx + 2'd1;
      end
      if (ctl.secInit) begin
        secPos    <= '0;
        secIsCode <= ctl.secSel;
      end
      if (ctl.wordWr) begin
        mbxWrEn <= 1'b1;
        mbxData <= shiftR;
        mbxAddr <= (secIsCode ? CODE_BASE : DATA_BASE) + 32'(secPos);
        secPos  <= secPos + LEN_W'(4);
      end
    end
  end

  always_comb begin
    stat.busy      = rdEn || capEn;
    stat.lenOk     = imgLen >= LEN_W'(2);
    stat.crcMatch  = crc == shiftR[15:0];
    stat.primFit   = imgLen >= LEN_W'(PRIM_FIELD_AT + 2);
    stat.hdrFit    = fits(prim, LEN_W'(HDR_AT + HDR_LEN), '0, imgLen);
    stat.lastField = fieldIdx == 2'd3;
    stat.codeAlign = codeSz[1:0] == 2'b00;
    stat.dataAlign = dataSz[1:0] == 2'b00;
    stat.codeFit   = fits(prim, LEN_W'(codeOff), LEN_W'(codeSz), imgLen);
    stat.dataFit   = fits(prim, LEN_W'(dataOff), LEN_W'(dataSz), imgLen);
    stat.verFit    = fits(prim, LEN_W'(dataOff), LEN_W'(VER_AT + VER_LEN), imgLen);
    stat.verNz     = shiftR[7:0] != 8'h00;
    stat.secDone   = secPos == secSize;
    stat.loadOk    = crc == mbxCrc;
  end

endmodule

// File: rtl/fwboot_ctrl.sv
module fwboot_ctrl
  import fwboot_pkg::*;
#(
  parameter int HOLD_CYC = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  dp_stat_t   stat,
  output dp_ctrl_t   ctl,
  output logic       cpuStall,
  output logic       cpuStallOvd,
  output logic       cpuRst,
  output logic       pwrClr,
  output logic       done,
  output logic       err,
  output logic [2:0] errCode
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  typedef enum logic [4:0] {
    S_IDLE, S_BODY, S_BODY_W, S_TRAIL, S_TRAIL_W, S_PRIM, S_PRIM_W, S_HDR,
    S_FIELD, S_FIELD_W, S_CHECK, S_VER, S_VER_W, S_SEC, S_WORD, S_WORD_W,
    S_SECEND, S_PWR, S_RST, S_HOLD
  } state_e;

  state_e            state;
  logic              curCode;
  logic [HOLD_W-1:0] holdCnt;

  always_comb begin
    ctl = '0;
    ctl.burstSel = B_BODY;
    case (state)
      S_IDLE:    ctl.crcClr = start;
      S_BODY:    ctl.burstGo = 1'b1;
      S_TRAIL:   begin ctl.burstGo = 1'b1; ctl.burstSel = B_TRAIL; end
      S_PRIM:    begin ctl.burstGo = 1'b1; ctl.burstSel = B_PRIM; end
      S_PRIM_W:  ctl.latchPrim = !stat.busy;
      S_FIELD:   begin ctl.burstGo = 1'b1; ctl.burstSel = B_FIELD; end
      S_FIELD_W: ctl.latchField = !stat.busy;
      S_VER:     begin ctl.burstGo = 1'b1; ctl.burstSel = B_VER; end
      S_SEC:     begin ctl.secInit = 1'b1; ctl.secSel = curCode; ctl.crcClr = 1'b1; end
      S_WORD:    begin ctl.burstGo = !stat.secDone; ctl.burstSel = B_WORD; end
      S_WORD_W:  ctl.wordWr = !stat.busy;
      default:   ;
    endcase
  end

  task automatic failWith(input err_e code);
    err     <= 1'b1;
    errCode <= code;
    state   <= S_IDLE;
  endtask

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; curCode <= 1'b0; holdCnt <= '0;
      cpuStall <= 1'b0; cpuStallOvd <= 1'b0; cpuRst <= 1'b0; pwrClr <= 1'b0;
      done <= 1'b0; err <= 1'b0; errCode <= ERR_NONE;
    end else begin
      pwrClr <= (state == S_PWR);
      case (state)
        S_IDLE: if (start) begin
          done <= 1'b0; err <= 1'b0; errCode <= ERR_NONE;
          if (stat.lenOk) state <= S_BODY;
          else failWith(ERR_IMG_CRC);
        end
        S_BODY:   state <= S_BODY_W;
        S_BODY_W: if (!stat.busy) state <= S_TRAIL;
        S_TRAIL:  state <= S_TRAIL_W;
        S_TRAIL_W: if (!stat.busy) begin
          if (!stat.crcMatch)     failWith(ERR_IMG_CRC);
          else if (!stat.primFit) failWith(ERR_HDR);
          else                    state <= S_PRIM;
        end
        S_PRIM:    state <= S_PRIM_W;
        S_PRIM_W:  if (!stat.busy) state <= S_HDR;
        S_HDR:     if (stat.hdrFit) state <= S_FIELD; else failWith(ERR_HDR);
        S_FIELD:   state <= S_FIELD_W;
        S_FIELD_W: if (!stat.busy) state <= stat.lastField ? S_CHECK : S_FIELD;
        S_CHECK: begin
          if (!stat.codeAlign)      failWith(ERR_ALIGN);
          else if (!stat.codeFit)   failWith(ERR_BOUND);
          else if (!stat.dataAlign) failWith(ERR_ALIGN);
          else if (!stat.dataFit)   failWith(ERR_BOUND);
          else if (!stat.verFit)    failWith(ERR_VER);
          else                      state <= S_VER;
        end
        S_VER:   state <= S_VER_W;
        S_VER_W: if (!stat.busy) begin
          if (stat.verNz) begin
            cpuStall <= 1'b1; cpuStallOvd <= 1'b1; curCode <= 1'b0; state <= S_SEC;
          end else failWith(ERR_VER);
        end
        S_SEC:    state <= S_WORD;
        S_WORD:   state <= stat.secDone ? S_SECEND : S_WORD_W;
        S_WORD_W: if (!stat.busy) state <= S_WORD;
        S_SECEND: begin
          if (!stat.loadOk) failWith(ERR_LOAD_CRC);
          else if (curCode) state <= S_PWR;
          else begin curCode <= 1'b1; state <= S_SEC; end
        end
        S_PWR: state <= S_RST;
        S_RST: begin
          cpuRst <= 1'b1; holdCnt <= HOLD_W'(HOLD_CYC - 1); state <= S_HOLD;
        end
        S_HOLD: begin
          if (holdCnt == '0) begin
            cpuRst <= 1'b0; cpuStall <= 1'b0; done <= 1'b1; state <= S_IDLE;
          end else holdCnt <= holdCnt - HOLD_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fwboot_seq.sv
module fwboot_seq
  import fwboot_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 32,
  parameter int CLK_HZ  = 50_000_000,
  parameter int HOLD_US = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  imgLen,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              mbxWrEn,
  output logic [31:0]       mbxAddr,
  output logic [31:0]       mbxData,
  output logic              mbxCrcClr,
  input  logic [15:0]       mbxCrc,
  output logic              cpuStall,
  output logic              cpuStallOvd,
  output logic              cpuRst,
  output logic              pwrClr,
  output logic              done,
  output logic              err,
  output logic [2:0]        errCode
);
  localparam int HOLD_RAW = (CLK_HZ / 1_000_000) * HOLD_US;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;

  dp_ctrl_t ctl;
  dp_stat_t stat;

  fwboot_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat), .ctl(ctl),
    .cpuStall(cpuStall), .cpuStallOvd(cpuStallOvd), .cpuRst(cpuRst),
    .pwrClr(pwrClr), .done(done), .err(err), .errCode(errCode)
  );

  fwboot_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .imgLen(imgLen), .rdData(rdData),
    .mbxCrc(mbxCrc), .stat(stat), .rdEn(rdEn), .rdAddr(rdAddr),
    .mbxWrEn(mbxWrEn), .mbxAddr(mbxAddr), .mbxData(mbxData), .mbxCrcClr(mbxCrcClr)
  );

endmodule

// File: rtl/fwboot_seq_chk.sv
module fwboot_seq_chk #(
  parameter int ADDR_W   = 24,
  parameter int LEN_W    = 32,
  parameter int HOLD_CYC = 5000
) (
  input logic              clk,
  input logic              rstN,
  input logic [LEN_W-1:0]  imgLen,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              mbxWrEn,
  input logic [31:0]       mbxAddr,
  input logic              cpuStall,
  input logic              cpuStallOvd,
  input logic              cpuRst,
  input logic              done,
  input logic              err,
  input logic [2:0]        errCode
);
  logic [31:0] rstRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rstRun <= '0;
    else if (cpuRst) rstRun <= rstRun + 32'd1;
    else             rstRun <= '0;
  end

  AST_RST_UNDER_STALL: assert property (@(posedge clk) disable iff (!rstN)
    cpuRst |-> (cpuStall && cpuStallOvd)); // R8
  AST_RST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuRst) |-> (rstRun >= 32'(HOLD_CYC))); // R8
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!cpuStall && cpuStallOvd && !cpuRst)); // R8
  AST_WR_UNDER_STALL: assert property (@(posedge clk) disable iff (!rstN)
    mbxWrEn |-> (cpuStall && cpuStallOvd && !cpuRst)); // R6
  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    mbxWrEn |-> (mbxAddr[1:0] == 2'b00)); // R6
  AST_RD_IN_IMAGE: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (LEN_W'(rdAddr) < imgLen)); // R4
  AST_ERR_NO_RST: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!cpuRst && !done && errCode != 3'd0)); // R9
  AST_ERR_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (err && $past(err)) |-> $stable(errCode)); // R9

endmodule

bind fwboot_seq fwboot_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .imgLen(imgLen), .rdEn(rdEn), .rdAddr(rdAddr),
  .mbxWrEn(mbxWrEn), .mbxAddr(mbxAddr), .cpuStall(cpuStall), .cpuStallOvd(cpuStallOvd),
  .cpuRst(cpuRst), .done(done), .err(err), .errCode(errCode)
);

// File: tb/fwboot_seq_tb.sv
`timescale 1ns/1ps
module fwboot_seq_tb;
  localparam int HOLD = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] imgLen = '0;
  logic        rdEn, mbxWrEn, mbxCrcClr, cpuStall, cpuStallOvd, cpuRst, pwrClr, done, err;
  logic [23:0] rdAddr;
  logic [7:0]  rdData = '0;
  logic [31:0] mbxAddr, mbxData;
  logic [15:0] mbxCrc = '0;
  logic [2:0]  errCode;

  logic [7:0]  mem [0:8191];
  logic [31:0] wrA [0:15];
  logic [31:0] wrD [0:15];
  int          wrCnt = 0, rstCyc = 0, pwrCnt = 0, cyc = 0;
  logic        logClr = 1'b0, mbxCorrupt = 1'b0;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  fwboot_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .imgLen(imgLen), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .mbxWrEn(mbxWrEn), .mbxAddr(mbxAddr), .mbxData(mbxData),
    .mbxCrcClr(mbxCrcClr), .mbxCrc(mbxCrc), .cpuStall(cpuStall), .cpuStallOvd(cpuStallOvd),
    .cpuRst(cpuRst), .pwrClr(pwrClr), .done(done), .err(err), .errCode(errCode)
  );

  function automatic logic [15:0] crcB(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb = r[15] ^ b[k];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rdEn) rdData <= mem[rdAddr[12:0]];
    if (mbxCrcClr) mbxCrc <= '0;
    if (mbxWrEn) begin
      if (wrCnt < 16) begin wrA[wrCnt] <= mbxAddr; wrD[wrCnt] <= mbxData; end
      mbxCrc <= crcB(crcB(crcB(crcB(mbxCrc, mbxData[31:24]), mbxData[23:16]),
                mbxData[15:8]), mbxData[7:0]) ^ {15'd0, mbxCorrupt};
    end
    if (logClr) begin wrCnt <= 0; rstCyc <= 0; pwrCnt <= 0; end
    else begin
      if (mbxWrEn) wrCnt <= wrCnt + 1;
      if (cpuRst) rstCyc <= rstCyc + 1;
      if (pwrClr) pwrCnt <= pwrCnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input int len, input int primRaw, input int cOff, input int cSz,
                       input int dOff, input int dSz, input logic [7:0] ver);
    int base = primRaw << 12;
    int h = base + 'h300;
    logic [15:0] c = '0;
    for (int i = 0; i < 8192; i++) mem[i] = 8'((i * 13 + 5) ^ (i >> 8));
    mem[8] = primRaw[7:0]; mem[9] = primRaw[15:8];
    mem[h+4]  = cOff[7:0]; mem[h+5]  = cOff[15:8]; mem[h+6]  = cOff[23:16];
    mem[h+7]  = cSz[7:0];  mem[h+8]  = cSz[15:8];  mem[h+9]  = cSz[23:16];
    mem[h+10] = dOff[7:0]; mem[h+11] = dOff[15:8]; mem[h+12] = dOff[23:16];
    mem[h+13] = dSz[7:0];  mem[h+14] = dSz[15:8];  mem[h+15] = dSz[23:16];
    if (base + dOff + 'h200 < 8192) mem[base + dOff + 'h200] = ver;
    if (len >= 2) begin
      for (int i = 0; i < len - 2; i++) c = crcB(c, mem[i]);
      mem[len-2] = c[15:8]; mem[len-1] = c[7:0];
    end
  endtask

  task automatic boot(input int len, input bit midStart, input bit corrupt);
    int n = 0;
    imgLen = len; mbxCorrupt = corrupt;
    @(negedge clk) logClr = 1'b1;
    @(negedge clk) logClr = 1'b0; start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!(done || err) && n < 40000) begin
      start = (midStart && n == 200);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (n >= 40000) chk(1'b0, "R9 run did not finish", n, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic expectGood(input string tag, input int base, input int cOff, input int cSz,
                            input int dOff, input int dSz);
    int nd = dSz / 4;
    int nc = cSz / 4;
    chk(done == 1'b1 && err == 1'b0, {tag, " R8 done"}, {done, err}, 2'b10);
    chk(errCode == 3'd0, {tag, " R8 code"}, errCode, 0);
    chk(wrCnt == nd + nc, {tag, " R6 write count"}, wrCnt, nd + nc);
    for (int k = 0; k < nd + nc && k < 16; k++) begin
      int src = (k < nd) ? base + dOff + 4 * k : base + cOff + 4 * (k - nd);
      logic [31:0] ea = (k < nd) ? 32'h3FFE0000 + 32'(4 * k) : 32'h40000000 + 32'(4 * (k - nd));
      logic [31:0] ed = {mem[src+3], mem[src+2], mem[src+1], mem[src]};
      chk(wrA[k] == ea, {tag, " R6 address"}, wrA[k], ea);
      chk(wrD[k] == ed, {tag, " R6 word"}, wrD[k], ed);
    end
    chk(rstCyc == HOLD, {tag, " R8 reset hold"}, rstCyc, HOLD);
    chk(pwrCnt == 1, {tag, " R8 power clear pulse"}, pwrCnt, 1);
    chk({cpuStall, cpuStallOvd, cpuRst} == 3'b010, {tag, " R8 final controls"},
        {cpuStall, cpuStallOvd, cpuRst}, 3'b010);
  endtask

  task automatic expectErr(input string tag, input logic [2:0] code, input int nWr,
                           input logic stall);
    chk(err == 1'b1 && done == 1'b0, {tag, " R9 err flag"}, {done, err}, 2'b01);
    chk(errCode == code, {tag, " errCode"}, errCode, code);
    chk(wrCnt == nWr, {tag, " write count"}, wrCnt, nWr);
    chk(rstCyc == 0 && pwrCnt == 0, {tag, " R9 no reset release"}, rstCyc, 0);
    chk(cpuStall == stall, {tag, " stall level"}, cpuStall, stall);
  endtask

  task automatic t_reset;
    chk({done, err, errCode, rdEn, mbxWrEn, cpuStall, cpuStallOvd, cpuRst, pwrClr} == '0,
        "R10 reset outputs", {done, err, errCode, rdEn, mbxWrEn, cpuStall, cpuStallOvd, cpuRst, pwrClr}, 0);
  endtask

  task automatic t_good_flat;
    build('h600, 0, 'h320, 16, 'h340, 8, 8'h41);
    boot('h600, 1'b0, 1'b0);
    expectGood("R2 R6 base0", 0, 'h320, 16, 'h340, 8);
  endtask

  task automatic t_good_reloc;
    build('h1600, 1, 'h320, 12, 'h340, 4, 8'h56);
    boot('h1600, 1'b0, 1'b0);
    expectGood("R2 R6 base1000", 'h1000, 'h320, 12, 'h340, 4);
  endtask

  task automatic t_bad_image_crc;
    build('h600, 0, 'h320, 16, 'h340, 8, 8'h41);
    mem['h20] = mem['h20] ^ 8'h01;
    boot('h600, 1'b0, 1'b0);
    expectErr("R1 corrupt byte", 3'd1, 0, 1'b0);
    build(8, 0, 0, 0, 0, 0, 8'h00);
    boot(1, 1'b0, 1'b0);
    expectErr("R1 length 1", 3'd1, 0, 1'b0);
  endtask

  task automatic t_header;
    build(8, 0, 0, 0, 0, 0, 8'h00);
    boot(8, 1'b0, 1'b0);
    expectErr("R2 length 8", 3'd2, 0, 1'b0);
    build('h1200, 1, 'h320, 16, 'h340, 8, 8'h41);
    boot('h1200, 1'b0, 1'b0);
    expectErr("R2 header past end", 3'd2, 0, 1'b0);
  endtask

  task automatic t_align;
    build('h600, 0, 'h320, 6, 'h340, 8, 8'h41);
    boot('h600, 1'b0, 1'b0);
    expectErr("R3 code size 6", 3'd3, 0, 1'b0);
    build('h600, 0, 'h320, 16, 'h340, 6, 8'h41);
    boot('h600, 1'b0, 1'b0);
    expectErr("R3 data size 6", 3'd3, 0, 1'b0);
  endtask

  task automatic t_bounds;
    build('h600, 0, 'h5F8, 16, 'h340, 8, 8'h41);
    boot('h600, 1'b0, 1'b0);
    expectErr("R4 code past end", 3'd4, 0, 1'b0);
  endtask

  task automatic t_version;
    build('h600, 0, 'h320, 16, 'h340, 8, 8'h00);
    boot('h600, 1'b0, 1'b0);
    expectErr("R5 empty version", 3'd5, 0, 1'b0);
    build('h600, 0, 'h320, 16, 'h400, 4, 8'h41);
    boot('h600, 1'b0, 1'b0);
    expectErr("R5 version past end", 3'd5, 0, 1'b0);
  endtask

  task automatic t_load_crc;
    build('h600, 0, 'h320, 16, 'h340, 8, 8'h41);
    boot('h600, 1'b0, 1'b1);
    expectErr("R7 mailbox crc", 3'd6, 2, 1'b1);
    chk(cpuStallOvd == 1'b1, "R7 override kept", cpuStallOvd, 1);
  endtask

  task automatic t_busy_start;
    build('h600, 0, 'h320, 16, 'h340, 8, 8'h41);
    boot('h600, 1'b1, 1'b0);
    expectGood("R9 start while busy", 0, 'h320, 16, 'h340, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_flat();
    t_good_reloc();
    t_bad_image_crc();
    t_header();
    t_align();
    t_bounds();
    t_version();
    t_load_crc();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule